// File: doc/BRIEF.md
# Memory Access Response Watchdog

This block supervises the handshake between a requester and an attached message memory. When an access starts, a down-counter is loaded from a programmable reload value. Each clock the counter waits, it counts down by one. A ready response from the memory reloads the counter and closes the pending access, and the counter then holds. If the count reaches zero before ready arrives, the counter freezes at zero and a sticky timeout flag rises. Software clears the flag by writing one to the clear input.

The reload value is an 8-bit configuration field. The block presents it back next to the live counter value, which is read-only. A reload value of zero turns the watchdog off. The counter runs on the peripheral bus clock. The memory and the routing of the timeout to an interrupt line sit outside the block.

Top module: `mem_resp_wdog`

## Requirements
- R1: After reset the counter value is 0, the timeout flag is 0 and no access is pending.
- R2: With a nonzero reload value, acc_start high at a clock edge loads the counter with the reload value and marks an access pending. The loaded value is visible after that edge.
- R3: While an access is pending and neither acc_start nor mem_ready is high, the counter decreases by exactly 1 at each clock edge.
- R4: mem_ready high while an access is pending reloads the counter with the reload value and ends the pending access.
- R5: The edge that brings a pending count to 0 also sets the timeout flag. The counter then stays at 0, and mem_ready has no effect, until the next acc_start.
- R6: The timeout flag stays set until flag_clr is high at a clock edge. flag_clr low leaves it set. When a timeout and flag_clr occur at the same edge, the flag ends up set.
- R7: A reload value of 0 disables the watchdog. acc_start is ignored, any pending access is dropped, the counter holds its value and the flag is not set.
- R8: With no access pending, the counter holds its value and mem_ready is ignored.
- R9: acc_start takes priority over mem_ready. A start during a pending access restarts the count from the reload value.
- R10: reload_val always shows the present value of cfg_reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_start | input | 1 | Pulse: a memory access begins |
| mem_ready | input | 1 | Pulse: the memory completed the access |
| cfg_reload | input | 8 | Programmed reload value; 0 disables |
| flag_clr | input | 1 | Write-one-to-clear for the timeout flag |
| reload_val | output | 8 | Configured reload value, read back |
| cnt_val | output | 8 | Live counter value |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
The bench counts the timeout edge precisely. A design that sets the flag one edge late, or lets the counter wrap to 255, fails the check that expects 0 and a set flag exactly reload-value edges after the start. The bench also sends mem_ready after a timeout and with no access pending, which catches a design that reloads a frozen or idle counter. It issues a clear in the same edge as an expiry to catch a design that lets the clear win. Finally it changes the reload value to zero in the middle of an access, and then back to nonzero without a start, to expose a design that keeps counting or still holds a stale pending state.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_cmd_e;

endpackage

// File: rtl/mrw_ctrl.sv
module mrw_ctrl
    import mrw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_start,
    input  logic         mem_ready,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] cnt_q,
    output cnt_cmd_e     cmd,
    output logic         expire
);

    typedef struct packed {
        logic pending;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    cnt_cmd_e    cmd_d;
    logic        expire_d;
    logic        enabled;

    always_comb begin
        st_d     = st_q;
        cmd_d    = CNT_HOLD;
        expire_d = 1'b0;
        enabled  = (reload != '0);
        if (!enabled) begin
            st_d.pending = 1'b0;
        end else if (acc_start) begin
            cmd_d        = CNT_LOAD;
            st_d.pending = 1'b1;
        end else if (st_q.pending && mem_ready) begin
            cmd_d        = CNT_LOAD;
            st_d.pending = 1'b0;
        end else if (st_q.pending) begin
            cmd_d = CNT_DEC;
            if (cnt_q <= W'(1)) begin
                expire_d     = 1'b1;
                st_d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd    = cmd_d;
    assign expire = expire_d;

endmodule

// File: rtl/mrw_counter.sv
module mrw_counter
    import mrw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_cmd_e     cmd,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt_q
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            CNT_LOAD: st_d.cnt = reload;
            CNT_DEC: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - W'(1);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/mrw_flag.sv
module mrw_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;

endmodule

// File: rtl/mem_resp_wdog.sv
module mem_resp_wdog
    import mrw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_start,
    input  logic         mem_ready,
    input  logic [W-1:0] cfg_reload,
    input  logic         flag_clr,
    output logic [W-1:0] reload_val,
    output logic [W-1:0] cnt_val,
    output logic         timeout_flag
);

    cnt_cmd_e     cmd;
    logic         expire;
    logic [W-1:0] cnt_q;

    mrw_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .mem_ready (mem_ready),
        .reload    (cfg_reload),
        .cnt_q     (cnt_q),
        .cmd       (cmd),
        .expire    (expire)
    );

    mrw_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .reload (cfg_reload),
        .cnt_q  (cnt_q)
    );

    mrw_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (expire),
        .clr    (flag_clr),
        .flag_q (timeout_flag)
    );

    assign cnt_val    = cnt_q;
    assign reload_val = cfg_reload;

endmodule

// File: rtl/mrw_checker.sv
module mrw_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         acc_start,
    input logic         mem_ready,
    input logic [W-1:0] cfg_reload,
    input logic         flag_clr,
    input logic [W-1:0] reload_val,
    input logic [W-1:0] cnt_val,
    input logic         timeout_flag
);

    // R2: a start with a nonzero reload loads the counter
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && cfg_reload != '0) |=> (cnt_val == $past(cfg_reload)));

    // R3: without a load, any change of the counter is a step of one down
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(acc_start) && !$past(mem_ready) && cnt_val != $past(cnt_val))
        |-> (cnt_val == $past(cnt_val) - W'(1)));

    // R5: the flag rises only together with a zero count
    p_flag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (cnt_val == '0));

    // R5: a zero count stays frozen without a start
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == '0 && !acc_start) |=> (cnt_val == '0));

    // R6: the flag is sticky while no clear is applied
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !flag_clr) |=> timeout_flag);

    // R7: a zero reload value freezes the counter
    p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reload == '0) |=> $stable(cnt_val));

    // R7: a zero reload value never raises the flag
    p_disabled_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reload == '0 && !timeout_flag) |=> !timeout_flag);

    // R10: read-back mirrors the configuration
    p_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reload_val == cfg_reload);

endmodule

bind mem_resp_wdog mrw_checker #(.W(W)) u_mrw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_start    (acc_start),
    .mem_ready    (mem_ready),
    .cfg_reload   (cfg_reload),
    .flag_clr     (flag_clr),
    .reload_val   (reload_val),
    .cnt_val      (cnt_val),
    .timeout_flag (timeout_flag)
);

// File: tb/mem_resp_wdog_test.sv
module mem_resp_wdog_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start = 1'b0;
    logic       mem_ready = 1'b0;
    logic [7:0] cfg_reload = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] reload_val;
    logic [7:0] cnt_val;
    logic       timeout_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    mem_resp_wdog #(.W(8)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start    (acc_start),
        .mem_ready    (mem_ready),
        .cfg_reload   (cfg_reload),
        .flag_clr     (flag_clr),
        .reload_val   (reload_val),
        .cnt_val      (cnt_val),
        .timeout_flag (timeout_flag)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic t_reset();
        check("R1 counter", cnt_val, 0);
        check("R1 flag", timeout_flag, 0);
    endtask

    task automatic t_load_and_count();
        cfg_reload = 8'd5;
        #1 check("R10 readback", reload_val, 5);
        acc_start = 1'b1; step(); acc_start = 1'b0;
        check("R2 load", cnt_val, 5);
        step(); check("R3 dec 1", cnt_val, 4);
        step(); check("R3 dec 2", cnt_val, 3);
    endtask

    task automatic t_ready_reload();
        mem_ready = 1'b1; step(); mem_ready = 1'b0;
        check("R4 reload", cnt_val, 5);
        step(); step(); step();
        check("R8 idle hold", cnt_val, 5);
        cfg_reload = 8'd7;
        #1 check("R10 readback 7", reload_val, 7);
        mem_ready = 1'b1; step(); mem_ready = 1'b0;
        check("R8 ready ignored when idle", cnt_val, 5);
        cfg_reload = 8'd5;
    endtask

    task automatic t_timeout();
        acc_start = 1'b1; step(); acc_start = 1'b0;
        check("R2 load again", cnt_val, 5);
        for (int i = 0; i < 4; i++) step();
        check("R3 count at 1", cnt_val, 1);
        check("R5 no flag before zero", timeout_flag, 0);
        step();
        check("R5 zero", cnt_val, 0);
        check("R5 flag set", timeout_flag, 1);
        step(); step(); step();
        check("R5 frozen", cnt_val, 0);
        mem_ready = 1'b1; step(); mem_ready = 1'b0;
        check("R5 ready after timeout ignored", cnt_val, 0);
    endtask

    task automatic t_clear();
        step(); step();
        check("R6 sticky without clear", timeout_flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check("R6 cleared", timeout_flag, 0);
        cfg_reload = 8'd1;
        acc_start = 1'b1; step(); acc_start = 1'b0;
        check("R2 load one", cnt_val, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check("R6 set beats clear", timeout_flag, 1);
        check("R5 zero after one", cnt_val, 0);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check("R6 cleared again", timeout_flag, 0);
    endtask

    task automatic t_restart();
        cfg_reload = 8'd6;
        acc_start = 1'b1; step(); acc_start = 1'b0;
        step(); step();
        check("R3 count 4", cnt_val, 4);
        acc_start = 1'b1; mem_ready = 1'b1; step();
        acc_start = 1'b0; mem_ready = 1'b0;
        check("R9 restart", cnt_val, 6);
        step();
        check("R9 start wins, still pending", cnt_val, 5);
    endtask

    task automatic t_disable();
        cfg_reload = 8'd0;
        step(); step(); step();
        check("R7 halted", cnt_val, 5);
        check("R7 no flag", timeout_flag, 0);
        acc_start = 1'b1; step(); acc_start = 1'b0;
        check("R7 start ignored", cnt_val, 5);
        cfg_reload = 8'd3;
        step(); step();
        check("R7 pending dropped", cnt_val, 5);
        acc_start = 1'b1; step(); acc_start = 1'b0;
        check("R2 load three", cnt_val, 3);
        for (int i = 0; i < 3; i++) step();
        check("R5 flag after three", timeout_flag, 1);
    endtask

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_load_and_count();
        t_ready_reload();
        t_timeout();
        t_clear();
        t_restart();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule